// File: doc/BRIEF.md
# Unified Oldest-First Issue Queue

This block is the single scheduling window of an out-of-order core, placed after register renaming. Integer ALU, multiply/divide and load/store micro-ops all wait in one shared pool of slots. An entry records only the physical tags of its destination and its two sources, a ready flag per source, its op class and an identifier. Operand values are read from the physical register file after issue, so the queue stores no data.

Result tags broadcast on the writeback bus set the ready flags of waiting sources. Each cycle, every execution port takes the oldest entry of its class whose sources are both ready. An age matrix records the relative order of the entries, so a freed low-numbered slot that is refilled later still counts as younger. The multiply/divide unit accepts one operation at a time, and the queue holds back further multiply/divide ops until that unit reports completion. A flush empties the queue in one cycle.

Top module: `age_issue_queue`

## Requirements
- R1: Class code 0 (ALU) issues only on port 0, code 1 (multiply/divide) only on port 1, and code 2 (memory) only on port 2. Different ports may issue in the same cycle.
- R2: On each port the oldest eligible entry in dispatch order is issued, whichever slot it occupies.
- R3: An entry is eligible only when both of its source ready flags are set and the grant input of its port is high. The issue output appears combinationally in the same cycle.
- R4: A valid wakeup tag on any wakeup lane sets the ready flag of every waiting source with that tag. The entry becomes eligible from the following cycle. A tag that does not match has no effect.
- R5: A wakeup whose tag matches a source of the micro-op being dispatched in that same cycle stores that source as ready.
- R6: An issued micro-op presents its identifier, destination tag and both source tags on its port.
- R7: After a multiply/divide op issues, no other multiply/divide op issues until `mdu_done` has been high for one cycle. A waiting op may issue in the cycle after that pulse.
- R8: When `flush` is high, nothing issues and dispatch is ignored in that cycle. From the next cycle the queue is empty.
- R9: `disp_ready` is low when every slot is valid and nothing issues. It is high in the same cycle that an entry issues from a full queue.
- R10: After reset the queue is empty, `disp_ready` is high and no port issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all queued entries |
| disp_valid | input | 1 | A micro-op is offered for dispatch |
| disp_ready | output | 1 | A slot is available for dispatch this cycle |
| disp_cls | input | 2 | Op class: 0 ALU, 1 multiply/divide, 2 memory |
| disp_id | input | ID_W | Micro-op identifier |
| disp_dst | input | TAG_W | Destination physical tag |
| disp_src1 | input | TAG_W | First source physical tag |
| disp_src1_rdy | input | 1 | First source already available |
| disp_src2 | input | TAG_W | Second source physical tag |
| disp_src2_rdy | input | 1 | Second source already available |
| wake_valid | input | NWAKE | Per-lane writeback tag valid |
| wake_tag | input | NWAKE*TAG_W | Writeback tags, lane k in bits k*TAG_W upward |
| mdu_done | input | 1 | Multiply/divide unit finished its op |
| iss_grant | input | 3 | Per-port permission to issue |
| iss_valid | output | 3 | Per-port issue strobe |
| iss_id | output | 3*ID_W | Issued identifiers, port p in bits p*ID_W upward |
| iss_dst | output | 3*TAG_W | Issued destination tags |
| iss_src1 | output | 3*TAG_W | Issued first source tags |
| iss_src2 | output | 3*TAG_W | Issued second source tags |

## Verification
The assertions assume that `disp_cls` never carries code 3. They also assume that `mdu_done` is raised only while a multiply/divide op is in flight, and that no tag is broadcast before its producer has been dispatched. The stimulus dispatches only the three defined class codes. It pulses `mdu_done` only after a multiply/divide issue, and it broadcasts only tags that some waiting source names or that deliberately match nothing. Inputs change just after a rising edge, and outputs are read before the next edge.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam int NPORT = 3;
    localparam int P_ALU = 0;
    localparam int P_MDU = 1;
    localparam int P_MEM = 2;

    typedef enum logic [1:0] {
        CLS_ALU = 2'd0,
        CLS_MDU = 2'd1,
        CLS_MEM = 2'd2
    } op_cls_e;

    function automatic logic cls_on_port(input logic [1:0] cls, input int port);
        return cls == 2'(port);
    endfunction
endpackage

// File: rtl/iq_wake_match.sv
module iq_wake_match #(
    parameter int TAG_W = 6,
    parameter int NWAKE = 2
) (
    input  logic [TAG_W-1:0]       tag,
    input  logic [NWAKE-1:0]       wake_valid,
    input  logic [NWAKE*TAG_W-1:0] wake_tag,
    output logic                   hit
);
    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < NWAKE; k++) begin
            if (wake_valid[k] && wake_tag[k*TAG_W +: TAG_W] == tag) hit = 1'b1;
        end
    end
endmodule

// File: rtl/iq_slot_pick.sv
module iq_slot_pick #(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0] free,
    output logic             found,
    output logic [DEPTH-1:0] pick_oh
);
    always_comb begin
        found   = 1'b0;
        pick_oh = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (free[i] && !found) begin
                pick_oh[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/iq_age_matrix.sv
module iq_age_matrix #(
    parameter int DEPTH = 8,
    parameter int NPORT = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   alloc_en,
    input  logic [DEPTH-1:0]       alloc_oh,
    input  logic [DEPTH-1:0]       live,
    input  logic [NPORT*DEPTH-1:0] req,
    output logic [NPORT*DEPTH-1:0] gnt
);
    // older_q[i][j] set: entry j was dispatched before entry i
    logic [DEPTH-1:0] older_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
        end else if (alloc_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (alloc_oh[i])      older_q[i][j] <= live[j];
                    else if (alloc_oh[j]) older_q[i][j] <= 1'b0;
                end
            end
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            assign gnt[p*DEPTH+i] = req[p*DEPTH+i] &
                                    ~|(req[p*DEPTH +: DEPTH] & older_q[i]);
        end
    end
endmodule

// File: rtl/age_issue_queue.sv
module age_issue_queue
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAG_W = 6,
    parameter int ID_W  = 6,
    parameter int NWAKE = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic                   disp_valid,
    output logic                   disp_ready,
    input  logic [1:0]             disp_cls,
    input  logic [ID_W-1:0]        disp_id,
    input  logic [TAG_W-1:0]       disp_dst,
    input  logic [TAG_W-1:0]       disp_src1,
    input  logic                   disp_src1_rdy,
    input  logic [TAG_W-1:0]       disp_src2,
    input  logic                   disp_src2_rdy,
    input  logic [NWAKE-1:0]       wake_valid,
    input  logic [NWAKE*TAG_W-1:0] wake_tag,
    input  logic                   mdu_done,
    input  logic [2:0]             iss_grant,
    output logic [2:0]             iss_valid,
    output logic [3*ID_W-1:0]      iss_id,
    output logic [3*TAG_W-1:0]     iss_dst,
    output logic [3*TAG_W-1:0]     iss_src1,
    output logic [3*TAG_W-1:0]     iss_src2
);
    typedef struct packed {
        logic [1:0]       cls;
        logic [ID_W-1:0]  id;
        logic [TAG_W-1:0] dst;
        logic [TAG_W-1:0] s1;
        logic [TAG_W-1:0] s2;
    } slot_t;

    slot_t            slot_q  [DEPTH];
    logic [DEPTH-1:0] valid_q, r1_q, r2_q;
    logic             mdu_busy_q;

    logic [DEPTH-1:0]       hit1, hit2, issued, free, alloc_oh;
    logic [NPORT*DEPTH-1:0] req, gnt;
    logic [NPORT-1:0]       port_en;
    logic                   found, disp_fire, dh1, dh2;

    for (genvar i = 0; i < DEPTH; i++) begin : g_wake
        iq_wake_match #(.TAG_W(TAG_W), .NWAKE(NWAKE)) u_m1 (
            .tag(slot_q[i].s1), .wake_valid(wake_valid), .wake_tag(wake_tag), .hit(hit1[i]));
        iq_wake_match #(.TAG_W(TAG_W), .NWAKE(NWAKE)) u_m2 (
            .tag(slot_q[i].s2), .wake_valid(wake_valid), .wake_tag(wake_tag), .hit(hit2[i]));
    end

    iq_wake_match #(.TAG_W(TAG_W), .NWAKE(NWAKE)) u_dm1 (
        .tag(disp_src1), .wake_valid(wake_valid), .wake_tag(wake_tag), .hit(dh1));
    iq_wake_match #(.TAG_W(TAG_W), .NWAKE(NWAKE)) u_dm2 (
        .tag(disp_src2), .wake_valid(wake_valid), .wake_tag(wake_tag), .hit(dh2));

    for (genvar p = 0; p < NPORT; p++) begin : g_req
        if (p == P_MDU) begin : g_mdu
            assign port_en[p] = iss_grant[p] & ~flush & ~mdu_busy_q;
        end else begin : g_plain
            assign port_en[p] = iss_grant[p] & ~flush;
        end
        for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            assign req[p*DEPTH+i] = port_en[p] & valid_q[i] & r1_q[i] & r2_q[i] &
                                    cls_on_port(slot_q[i].cls, p);
        end
    end

    iq_age_matrix #(.DEPTH(DEPTH), .NPORT(NPORT)) u_age (
        .clk(clk), .rst(rst), .alloc_en(disp_fire), .alloc_oh(alloc_oh),
        .live(valid_q & ~issued), .req(req), .gnt(gnt));

    always_comb begin
        issued   = '0;
        iss_id   = '0;
        iss_dst  = '0;
        iss_src1 = '0;
        iss_src2 = '0;
        for (int p = 0; p < NPORT; p++) begin
            iss_valid[p] = |gnt[p*DEPTH +: DEPTH];
            issued       = issued | gnt[p*DEPTH +: DEPTH];
            for (int i = 0; i < DEPTH; i++) begin
                if (gnt[p*DEPTH+i]) begin
                    iss_id[p*ID_W +: ID_W]     = slot_q[i].id;
                    iss_dst[p*TAG_W +: TAG_W]  = slot_q[i].dst;
                    iss_src1[p*TAG_W +: TAG_W] = slot_q[i].s1;
                    iss_src2[p*TAG_W +: TAG_W] = slot_q[i].s2;
                end
            end
        end
    end

    assign free = ~valid_q | issued;

    iq_slot_pick #(.DEPTH(DEPTH)) u_pick (.free(free), .found(found), .pick_oh(alloc_oh));

    assign disp_ready = found & ~flush;
    assign disp_fire  = disp_valid & disp_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q    <= '0;
            r1_q       <= '0;
            r2_q       <= '0;
            mdu_busy_q <= 1'b0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            if (iss_valid[P_MDU])  mdu_busy_q <= 1'b1;
            else if (mdu_done)     mdu_busy_q <= 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                if (flush) begin
                    valid_q[i] <= 1'b0;
                end else if (disp_fire && alloc_oh[i]) begin
                    valid_q[i] <= 1'b1;
                    slot_q[i]  <= '{cls: disp_cls, id: disp_id, dst: disp_dst,
                                    s1: disp_src1, s2: disp_src2};
                    r1_q[i]    <= disp_src1_rdy | dh1;
                    r2_q[i]    <= disp_src2_rdy | dh2;
                end else if (issued[i]) begin
                    valid_q[i] <= 1'b0;
                end else begin
                    r1_q[i] <= r1_q[i] | hit1[i];
                    r2_q[i] <= r2_q[i] | hit2[i];
                end
            end
        end
    end
endmodule

// File: rtl/age_issue_queue_chk.sv
module age_issue_queue_chk #(
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic [2:0]       iss_grant,
    input logic [2:0]       iss_valid,
    input logic [DEPTH-1:0] valid_q
);
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0)); // R8
    AST_FLUSH_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
        flush |-> (iss_valid == 3'b000)); // R8
    AST_GRANT_HONOURED: assert property (@(posedge clk) disable iff (rst)
        (iss_valid & ~iss_grant) == 3'b000); // R3
    AST_MDU_SINGLE: assert property (@(posedge clk) disable iff (rst)
        iss_valid[1] |=> !iss_valid[1]); // R7
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
        ((&valid_q) && iss_valid == 3'b000) |-> !disp_ready); // R9
    AST_OCCUPANCY: assert property (@(posedge clk) disable iff (rst)
        !flush |=> $countones(valid_q) == $past($countones(valid_q))
                   - $past($countones(iss_valid)) + $past(32'(disp_valid && disp_ready))); // R9
endmodule

bind age_issue_queue age_issue_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .flush(flush), .disp_valid(disp_valid),
    .disp_ready(disp_ready), .iss_grant(iss_grant), .iss_valid(iss_valid),
    .valid_q(valid_q));

// File: tb/age_issue_queue_test.sv
module age_issue_queue_test;
    localparam int DEPTH = 8;
    localparam int TAG_W = 6;
    localparam int ID_W  = 6;
    localparam int NWAKE = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0;
    logic disp_valid = 1'b0;
    logic disp_ready;
    logic [1:0] disp_cls = '0;
    logic [ID_W-1:0] disp_id = '0;
    logic [TAG_W-1:0] disp_dst = '0, disp_src1 = '0, disp_src2 = '0;
    logic disp_src1_rdy = 1'b0, disp_src2_rdy = 1'b0;
    logic [NWAKE-1:0] wake_valid = '0;
    logic [NWAKE*TAG_W-1:0] wake_tag = '0;
    logic mdu_done = 1'b0;
    logic [2:0] iss_grant = '0;
    logic [2:0] iss_valid;
    logic [3*ID_W-1:0] iss_id;
    logic [3*TAG_W-1:0] iss_dst, iss_src1, iss_src2;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    age_issue_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ID_W(ID_W), .NWAKE(NWAKE)) uut (
        .clk(clk), .rst(rst), .flush(flush), .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_cls(disp_cls), .disp_id(disp_id), .disp_dst(disp_dst),
        .disp_src1(disp_src1), .disp_src1_rdy(disp_src1_rdy),
        .disp_src2(disp_src2), .disp_src2_rdy(disp_src2_rdy),
        .wake_valid(wake_valid), .wake_tag(wake_tag), .mdu_done(mdu_done),
        .iss_grant(iss_grant), .iss_valid(iss_valid), .iss_id(iss_id),
        .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2));

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] cls, input int id, input int dst,
                       input int s1, input bit r1, input int s2, input bit r2);
        disp_valid = 1'b1; disp_cls = cls; disp_id = ID_W'(id); disp_dst = TAG_W'(dst);
        disp_src1 = TAG_W'(s1); disp_src1_rdy = r1; disp_src2 = TAG_W'(s2); disp_src2_rdy = r2;
    endtask

    task automatic idle_disp();
        disp_valid = 1'b0;
    endtask

    function automatic int port_id(input int p);
        return int'(iss_id[p*ID_W +: ID_W]);
    endfunction

    task automatic t_reset();
        #1;
        check(disp_ready == 1'b1, "R10 ready after reset", int'(disp_ready), 1);
        check(iss_valid == 3'b000, "R10 no issue after reset", int'(iss_valid), 0);
    endtask

    task automatic t_oldest_order();
        iss_grant = 3'b000;
        for (int k = 1; k <= 3; k++) begin
            put(2'd0, k, k + 10, 1, 1'b1, 2, 1'b1);
            cyc();
        end
        idle_disp();
        iss_grant = 3'b001;
        for (int k = 1; k <= 3; k++) begin
            #1;
            check(iss_valid[0] && port_id(0) == k, "R2 dispatch order", port_id(0), k);
            cyc();
        end
        check(iss_valid == 3'b000, "R2 drained", int'(iss_valid), 0);
        iss_grant = 3'b000;
    endtask

    task automatic t_slot_reuse();
        put(2'd0, 10, 1, 1, 1'b1, 1, 1'b1); cyc();
        put(2'd0, 11, 2, 1, 1'b1, 1, 1'b1); cyc();
        idle_disp();
        iss_grant = 3'b001;
        #1;
        check(port_id(0) == 10, "R2 first of pair", port_id(0), 10);
        cyc();
        iss_grant = 3'b000;
        put(2'd0, 12, 3, 1, 1'b1, 1, 1'b1); cyc();
        idle_disp();
        iss_grant = 3'b001;
        #1;
        check(iss_valid[0] && port_id(0) == 11, "R2 older in higher slot wins", port_id(0), 11);
        cyc();
        check(iss_valid[0] && port_id(0) == 12, "R2 reused slot issues last", port_id(0), 12);
        cyc();
        iss_grant = 3'b000;
    endtask

    task automatic t_wakeup();
        put(2'd0, 20, 33, 5, 1'b0, 6, 1'b1); cyc();
        idle_disp();
        iss_grant = 3'b001;
        #1;
        check(iss_valid[0] == 1'b0, "R3 blocked on source", int'(iss_valid), 0);
        wake_valid = 2'b01; wake_tag = {TAG_W'(0), TAG_W'(5)};
        #1;
        check(iss_valid[0] == 1'b0, "R4 not eligible in wake cycle", int'(iss_valid), 0);
        cyc();
        wake_valid = 2'b00;
        #1;
        check(iss_valid[0] && port_id(0) == 20, "R4 issues after wakeup", port_id(0), 20);
        check(iss_dst[0 +: TAG_W] == 33 && iss_src1[0 +: TAG_W] == 5 && iss_src2[0 +: TAG_W] == 6,
              "R6 tags on port", int'(iss_dst[0 +: TAG_W]), 33);
        cyc();
        put(2'd0, 21, 34, 1, 1'b1, 9, 1'b0); cyc();
        idle_disp();
        wake_valid = 2'b10; wake_tag = {TAG_W'(8), TAG_W'(0)};
        cyc();
        wake_valid = 2'b00;
        #1;
        check(iss_valid[0] == 1'b0, "R4 mismatched tag ignored", int'(iss_valid), 0);
        wake_valid = 2'b10; wake_tag = {TAG_W'(9), TAG_W'(0)};
        cyc();
        wake_valid = 2'b00;
        #1;
        check(iss_valid[0] && port_id(0) == 21, "R4 second lane wakes", port_id(0), 21);
        cyc();
        iss_grant = 3'b000;
    endtask

    task automatic t_same_cycle_wake();
        put(2'd0, 30, 40, 7, 1'b0, 7, 1'b0);
        wake_valid = 2'b01; wake_tag = {TAG_W'(0), TAG_W'(7)};
        cyc();
        idle_disp();
        wake_valid = 2'b00;
        iss_grant = 3'b001;
        #1;
        check(iss_valid[0] && port_id(0) == 30, "R5 wake during dispatch", port_id(0), 30);
        cyc();
        iss_grant = 3'b000;
    endtask

    task automatic t_mdu();
        put(2'd1, 40, 1, 1, 1'b1, 1, 1'b1); cyc();
        put(2'd1, 41, 2, 1, 1'b1, 1, 1'b1); cyc();
        idle_disp();
        iss_grant = 3'b010;
        #1;
        check(iss_valid == 3'b010 && port_id(1) == 40, "R7 first mdu op", port_id(1), 40);
        cyc();
        check(iss_valid[1] == 1'b0, "R7 held while busy", int'(iss_valid), 0);
        cyc();
        check(iss_valid[1] == 1'b0, "R7 still held", int'(iss_valid), 0);
        mdu_done = 1'b1;
        #1;
        check(iss_valid[1] == 1'b0, "R7 not in done cycle", int'(iss_valid), 0);
        cyc();
        mdu_done = 1'b0;
        #1;
        check(iss_valid[1] && port_id(1) == 41, "R7 second after done", port_id(1), 41);
        cyc();
        iss_grant = 3'b000;
        mdu_done = 1'b1; cyc(); mdu_done = 1'b0;
    endtask

    task automatic t_ports();
        put(2'd2, 50, 1, 1, 1'b1, 1, 1'b1); cyc();
        put(2'd0, 51, 2, 1, 1'b1, 1, 1'b1); cyc();
        idle_disp();
        iss_grant = 3'b111;
        #1;
        check(iss_valid == 3'b101, "R1 parallel ports", int'(iss_valid), 5);
        check(port_id(0) == 51 && port_id(2) == 50, "R1 class to port", port_id(2), 50);
        cyc();
        iss_grant = 3'b000;
    endtask

    task automatic t_full_and_flush();
        for (int k = 0; k < DEPTH; k++) begin
            put(2'd0, 60 - DEPTH + k, 1, 3, 1'b0, 3, 1'b0);
            cyc();
        end
        put(2'd0, 1, 1, 1, 1'b1, 1, 1'b1);
        #1;
        check(disp_ready == 1'b0, "R9 full stalls", int'(disp_ready), 0);
        cyc();
        idle_disp();
        wake_valid = 2'b01; wake_tag = {TAG_W'(0), TAG_W'(3)};
        cyc();
        wake_valid = 2'b00;
        iss_grant = 3'b001;
        #1;
        check(disp_ready == 1'b1, "R9 ready when issuing from full", int'(disp_ready), 1);
        check(port_id(0) == 60 - DEPTH, "R2 oldest of full queue", port_id(0), 60 - DEPTH);
        cyc();
        flush = 1'b1;
        put(2'd0, 2, 1, 1, 1'b1, 1, 1'b1);
        #1;
        check(iss_valid == 3'b000, "R8 no issue during flush", int'(iss_valid), 0);
        cyc();
        flush = 1'b0;
        idle_disp();
        #1;
        check(iss_valid == 3'b000, "R8 empty after flush", int'(iss_valid), 0);
        check(disp_ready == 1'b1, "R8 ready after flush", int'(disp_ready), 1);
        cyc();
        iss_grant = 3'b000;
    endtask

    initial begin
        cyc(); cyc();
        rst = 1'b0;
        t_reset();
        cyc();
        t_oldest_order();
        t_slot_reuse();
        t_wakeup();
        t_same_cycle_wake();
        t_mdu();
        t_ports();
        t_full_and_flush();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule